// File: doc/BRIEF.md
# AXI Write-Channel Memory Slave

This block is the write side of a small memory target on an AXI bus. It takes one write burst at a time over the write address, write data and write response channels. Data is 32 bits wide and IDs are 4 bits. After it accepts a burst address, it steps a beat address for each data beat. The fixed, incrementing and wrapping burst rules all come from one stepper. Each beat merges bytes into an internal byte array under the control of the lane strobes. When the burst ends, the block returns one response carrying the burst's ID.

A combinational lookup port reads four consecutive bytes of the array. The neighbouring read path uses it, and it lets stored contents be observed without a read channel.

A three-state controller sequences the channels. Its states are `ST_IDLE`, `ST_DATA` and `ST_RESP`, and it has three transitions:
- `ST_IDLE`→`ST_DATA` when the address handshake completes.
- `ST_DATA`→`ST_RESP` on the beat that ends the burst.
- `ST_RESP`→`ST_IDLE` when the response handshake completes.

Top module: `axi_wr_mem_slave`

## Requirements
- R1: An address beat is captured only in a cycle where `aw_valid` and `aw_ready` are both 1. A data beat is captured only in a cycle where `w_valid` and `w_ready` are both 1.
- R2: Only one burst is in flight at a time. `aw_ready` is 1 only in `ST_IDLE`, `w_ready` only in `ST_DATA` and `b_valid` only in `ST_RESP`, so no new address is accepted before the response handshake.
- R3: Bytes are placed little-endian. Strobe lane k (`w_data[8k+7:8k]`) goes to beat address + k.
- R4: Only lanes whose `w_strb` bit is 1 are written. Other bytes keep their previous value.
- R5: Burst code 2'b01 (incrementing) writes the first beat at the start address. Each later beat goes to the previous beat address aligned down to 2^size, plus 2^size. Sizes above 2 are treated as 2.
- R6: Burst code 2'b00 (fixed) writes every beat to the start address.
- R7: Burst code 2'b10 (wrapping) steps like R5 inside an aligned window of (len+1)·2^size bytes. It returns to the window's low end after the top. len+1 must be a power of two.
- R8: The cycle after the final data beat is accepted, `b_valid` is 1 and `b_id` equals the `aw_id` of the burst.
- R9: While `b_valid` is 1 and `b_ready` is 0, `b_valid`, `b_id` and `b_resp` hold steady.
- R10: Response codes are 2'b00 OKAY, 2'b10 DECERR and 2'b11 SLVERR; 2'b01 is never returned. A beat with any strobed byte outside [BASE_ADDR, BASE_ADDR+MEM_BYTES) is accepted but stores nothing, and the burst ends with DECERR.
- R11: The burst ends on the first beat that has `w_last`=1 or is counted as beat len. If `w_last` disagrees with the count on any beat, or `w_id` differs from the burst ID, the response is SLVERR. SLVERR takes precedence over DECERR.
- R12: `lk_data` returns the bytes at `lk_addr`+0..3 in lanes 0..3. Bytes outside the window read 0.
- R13: After reset, `aw_ready`=1, `w_ready`=0, `b_valid`=0 and every stored byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_id | input | 4 | Burst ID |
| aw_addr | input | 32 | Start address |
| aw_len | input | 8 | Beats minus one |
| aw_size | input | 3 | log2 of bytes per beat |
| aw_burst | input | 2 | 00 fixed, 01 incrementing, 10 wrapping |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| w_id | input | 4 | Data beat ID |
| w_data | input | 32 | Beat data |
| w_strb | input | 4 | Byte lane enables |
| w_last | input | 1 | Final beat marker |
| b_valid | output | 1 | Response valid |
| b_ready | input | 1 | Response ready |
| b_id | output | 4 | Response ID |
| b_resp | output | 2 | Response code |
| lk_addr | input | 32 | Lookup byte address |
| lk_data | output | 32 | Lookup data, little-endian |

## Verification
The bound checker covers the cycle-by-cycle rules on every clock:
- ready/valid exclusivity between the channels, and the blocking of new addresses during a response;
- response stability under backpressure;
- the response following a final beat one cycle later;
- the response ID matching the captured address ID;
- the absence of the EXOKAY code.

Only the bench scenarios can show the content rules: byte placement, strobe merging, the fixed, incrementing, wrapping and narrow address sequences, and which beats are dropped or flagged. These are read back through the lookup port and compared with addresses computed from the requirements.

// File: rtl/axi_wr_pkg.sv
`timescale 1ns/1ps
package axi_wr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_RESP = 2'd2
    } wr_state_e;

    typedef enum logic [1:0] {
        BURST_FIXED = 2'b00,
        BURST_INCR  = 2'b01,
        BURST_WRAP  = 2'b10
    } burst_kind_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_DECERR = 2'b10;
    localparam logic [1:0] RESP_SLVERR = 2'b11;

endpackage

// File: rtl/axi_wr_addr_step.sv
`timescale 1ns/1ps
module axi_wr_addr_step #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 8
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [1:0]        size,
    input  logic [LEN_W-1:0]  len,
    input  logic [1:0]        burst,
    output logic [ADDR_W-1:0] next_addr
);
    logic [ADDR_W-1:0] step_bytes;
    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] stepped;
    logic [ADDR_W-1:0] win_mask;

    always_comb begin
        step_bytes = ADDR_W'(1) << size;
        aligned    = cur_addr & ~(step_bytes - ADDR_W'(1));
        stepped    = aligned + step_bytes;
        win_mask   = ((ADDR_W'(len) + ADDR_W'(1)) << size) - ADDR_W'(1);
        unique case (burst)
            2'b00:   next_addr = cur_addr;
            2'b10:   next_addr = (cur_addr & ~win_mask) | (stepped & win_mask);
            default: next_addr = stepped;
        endcase
    end
endmodule

// File: rtl/axi_wr_byte_store.sv
`timescale 1ns/1ps
module axi_wr_byte_store #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned LANES     = 4,
    parameter int unsigned MEM_BYTES = 64,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [LANES*8-1:0]    wr_data,
    input  logic [LANES-1:0]      wr_strb,
    output logic                  wr_miss,
    input  logic [ADDR_W-1:0]     lk_addr,
    output logic [LANES*8-1:0]    lk_data
);
    localparam int unsigned IDX_W = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;

    logic [7:0]        mem [MEM_BYTES];
    logic [LANES-1:0]  wr_ok;
    logic [IDX_W-1:0]  wr_idx [LANES];
    logic [LANES-1:0]  lk_ok;
    logic [IDX_W-1:0]  lk_idx [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [ADDR_W:0] wr_off;
        logic [ADDR_W:0] lk_off;
        assign wr_off    = {1'b0, wr_addr} - {1'b0, BASE_ADDR} + (ADDR_W+1)'(k);
        assign lk_off    = {1'b0, lk_addr} - {1'b0, BASE_ADDR} + (ADDR_W+1)'(k);
        assign wr_ok[k]  = wr_off < (ADDR_W+1)'(MEM_BYTES);
        assign lk_ok[k]  = lk_off < (ADDR_W+1)'(MEM_BYTES);
        assign wr_idx[k] = wr_off[IDX_W-1:0];
        assign lk_idx[k] = lk_off[IDX_W-1:0];
        assign lk_data[8*k +: 8] = lk_ok[k] ? mem[lk_idx[k]] : 8'h00;
    end

    assign wr_miss = |(wr_strb & ~wr_ok);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h00;
        end else if (wr_en && !wr_miss) begin
            for (int k = 0; k < LANES; k++) begin
                if (wr_strb[k]) mem[wr_idx[k]] <= wr_data[8*k +: 8];
            end
        end
    end
endmodule

// File: rtl/axi_wr_mem_slave.sv
`timescale 1ns/1ps
module axi_wr_mem_slave
    import axi_wr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ID_W      = 4,
    parameter int unsigned LEN_W     = 8,
    parameter int unsigned MEM_BYTES = 64,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h1000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                aw_valid,
    output logic                aw_ready,
    input  logic [ID_W-1:0]     aw_id,
    input  logic [ADDR_W-1:0]   aw_addr,
    input  logic [LEN_W-1:0]    aw_len,
    input  logic [2:0]          aw_size,
    input  logic [1:0]          aw_burst,
    input  logic                w_valid,
    output logic                w_ready,
    input  logic [ID_W-1:0]     w_id,
    input  logic [DATA_W-1:0]   w_data,
    input  logic [DATA_W/8-1:0] w_strb,
    input  logic                w_last,
    output logic                b_valid,
    input  logic                b_ready,
    output logic [ID_W-1:0]     b_id,
    output logic [1:0]          b_resp,
    input  logic [ADDR_W-1:0]   lk_addr,
    output logic [DATA_W-1:0]   lk_data
);
    localparam int unsigned LANES = DATA_W / 8;

    wr_state_e         state_q;
    logic [ID_W-1:0]   id_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_nxt;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [1:0]        size_q;
    logic [1:0]        burst_q;
    logic              slv_q;
    logic              dec_q;

    logic aw_hs, w_hs, b_hs;
    logic count_final, burst_end, beat_bad, beat_miss;

    assign aw_hs       = aw_valid && aw_ready;
    assign w_hs        = w_valid && w_ready;
    assign b_hs        = b_valid && b_ready;
    assign count_final = (cnt_q == len_q);
    assign burst_end   = w_hs && (w_last || count_final);
    assign beat_bad    = (w_last != count_final) || (w_id != id_q);

    axi_wr_addr_step #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_step (
        .cur_addr (addr_q),
        .size     (size_q),
        .len      (len_q),
        .burst    (burst_q),
        .next_addr(addr_nxt)
    );

    axi_wr_byte_store #(
        .ADDR_W(ADDR_W), .LANES(LANES), .MEM_BYTES(MEM_BYTES), .BASE_ADDR(BASE_ADDR)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (w_hs),
        .wr_addr(addr_q),
        .wr_data(w_data),
        .wr_strb(w_strb),
        .wr_miss(beat_miss),
        .lk_addr(lk_addr),
        .lk_data(lk_data)
    );

    // State register with transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (aw_hs)     state_q <= ST_DATA;
                ST_DATA: if (burst_end) state_q <= ST_RESP;
                ST_RESP: if (b_hs)      state_q <= ST_IDLE;
                default:                state_q <= ST_IDLE;
            endcase
        end
    end

    // Burst context and error accumulation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q    <= '0;
            addr_q  <= '0;
            len_q   <= '0;
            cnt_q   <= '0;
            size_q  <= '0;
            burst_q <= BURST_INCR;
            slv_q   <= 1'b0;
            dec_q   <= 1'b0;
        end else if (aw_hs) begin
            id_q    <= aw_id;
            addr_q  <= aw_addr;
            len_q   <= aw_len;
            cnt_q   <= '0;
            size_q  <= (aw_size > 3'd2) ? 2'd2 : aw_size[1:0];
            burst_q <= aw_burst;
            slv_q   <= 1'b0;
            dec_q   <= 1'b0;
        end else if (w_hs) begin
            addr_q  <= addr_nxt;
            cnt_q   <= cnt_q + LEN_W'(1);
            slv_q   <= slv_q | beat_bad;
            dec_q   <= dec_q | beat_miss;
        end
    end

    // Outputs by state
    always_comb begin
        aw_ready = 1'b0;
        w_ready  = 1'b0;
        b_valid  = 1'b0;
        unique case (state_q)
            ST_IDLE: aw_ready = 1'b1;
            ST_DATA: w_ready  = 1'b1;
            ST_RESP: b_valid  = 1'b1;
            default: ;
        endcase
        b_id   = id_q;
        b_resp = slv_q ? RESP_SLVERR : (dec_q ? RESP_DECERR : RESP_OKAY);
    end
endmodule

// File: rtl/axi_wr_mem_slave_chk.sv
`timescale 1ns/1ps
module axi_wr_mem_slave_chk #(
    parameter int unsigned ID_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            aw_valid,
    input logic            aw_ready,
    input logic [ID_W-1:0] aw_id,
    input logic            w_valid,
    input logic            w_ready,
    input logic            w_last,
    input logic            b_valid,
    input logic            b_ready,
    input logic [ID_W-1:0] b_id,
    input logic [1:0]      b_resp
);
    logic [ID_W-1:0] seen_id;

    always_ff @(posedge clk) begin
        if (!rst_n)                    seen_id <= '0;
        else if (aw_valid && aw_ready) seen_id <= aw_id;
    end

    // R2
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(aw_ready && w_ready));

    // R2
    aw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> (!aw_ready && !w_ready));

    // R9
    b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && !b_ready) |=> (b_valid && $stable(b_id) && $stable(b_resp)));

    // R8
    resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && w_ready && w_last) |=> b_valid);

    // R8
    bid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> (b_id == seen_id));

    // R10
    no_exokay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> (b_resp != 2'b01));
endmodule

bind axi_wr_mem_slave axi_wr_mem_slave_chk #(.ID_W(ID_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .aw_valid(aw_valid),
    .aw_ready(aw_ready),
    .aw_id   (aw_id),
    .w_valid (w_valid),
    .w_ready (w_ready),
    .w_last  (w_last),
    .b_valid (b_valid),
    .b_ready (b_ready),
    .b_id    (b_id),
    .b_resp  (b_resp)
);

// File: tb/test_axi_wr_mem_slave.sv
`timescale 1ns/1ps
module test_axi_wr_mem_slave;
    localparam logic [31:0] BASE = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        aw_valid = 1'b0;
    logic        aw_ready;
    logic [3:0]  aw_id = '0;
    logic [31:0] aw_addr = '0;
    logic [7:0]  aw_len = '0;
    logic [2:0]  aw_size = '0;
    logic [1:0]  aw_burst = '0;
    logic        w_valid = 1'b0;
    logic        w_ready;
    logic [3:0]  w_id = '0;
    logic [31:0] w_data = '0;
    logic [3:0]  w_strb = '0;
    logic        w_last = 1'b0;
    logic        b_valid;
    logic        b_ready = 1'b0;
    logic [3:0]  b_id;
    logic [1:0]  b_resp;
    logic [31:0] lk_addr = '0;
    logic [31:0] lk_data;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    axi_wr_mem_slave i_axi_wr_mem_slave (
        .clk(clk), .rst_n(rst_n),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_addr(aw_addr),
        .aw_len(aw_len), .aw_size(aw_size), .aw_burst(aw_burst),
        .w_valid(w_valid), .w_ready(w_ready), .w_id(w_id), .w_data(w_data),
        .w_strb(w_strb), .w_last(w_last),
        .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
        .lk_addr(lk_addr), .lk_data(lk_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic peek(input string req, input logic [31:0] a, input logic [31:0] exp);
        lk_addr = a;
        #1;
        chk(req, lk_data, exp);
    endtask

    task automatic send_aw(input logic [3:0] id, input logic [31:0] a, input logic [7:0] len,
                           input logic [2:0] size, input logic [1:0] burst);
        aw_valid = 1'b1; aw_id = id; aw_addr = a; aw_len = len; aw_size = size; aw_burst = burst;
        while (!aw_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        aw_valid = 1'b0;
    endtask

    task automatic send_w(input logic [3:0] id, input logic [31:0] d, input logic [3:0] strb,
                          input logic last);
        w_valid = 1'b1; w_id = id; w_data = d; w_strb = strb; w_last = last;
        while (!w_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        w_valid = 1'b0; w_last = 1'b0;
    endtask

    task automatic take_b(input string req, input logic [3:0] id, input logic [1:0] resp,
                          input int hold);
        int waited = 0;
        while (!b_valid && waited < 20) begin @(negedge clk); waited++; end
        chk(req, {31'd0, b_valid}, 32'd1);
        chk(req, {28'd0, b_id}, {28'd0, id});
        chk(req, {30'd0, b_resp}, {30'd0, resp});
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            // R9 response held under backpressure; R2 no address acceptance meanwhile
            chk("R9", {29'd0, b_valid, b_resp}, {29'd0, 1'b1, resp});
            chk("R2", {31'd0, aw_ready}, 32'd0);
        end
        b_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        b_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk("R13", {29'd0, aw_ready, w_ready, b_valid}, {29'd0, 3'b100});
        peek("R13", BASE, 32'h0);
        peek("R12", BASE + 32'd60, 32'h0);
    endtask

    task automatic t_incr();
        send_aw(4'd11, BASE, 8'd1, 3'd2, 2'b01);
        chk("R2", {30'd0, aw_ready, w_ready}, 32'd1);
        send_w(4'd11, 32'h1234_5678, 4'hF, 1'b0);
        send_w(4'd11, 32'h4647_8343, 4'hF, 1'b1);
        chk("R8", {31'd0, b_valid}, 32'd1);
        take_b("R8", 4'd11, 2'b00, 0);
        peek("R5", BASE, 32'h1234_5678);
        peek("R5", BASE + 32'd4, 32'h4647_8343);
        peek("R3", BASE + 32'd1, 32'h4312_3456);
        chk("R1", {31'd0, aw_ready}, 32'd1);
    endtask

    task automatic t_strobe();
        send_aw(4'd2, BASE + 32'd8, 8'd0, 3'd2, 2'b01);
        send_w(4'd2, 32'h1122_3344, 4'hF, 1'b1);
        take_b("R4", 4'd2, 2'b00, 0);
        send_aw(4'd3, BASE + 32'd8, 8'd0, 3'd2, 2'b01);
        send_w(4'd3, 32'hAABB_CCDD, 4'b0011, 1'b1);
        take_b("R4", 4'd3, 2'b00, 0);
        peek("R4", BASE + 32'd8, 32'h1122_CCDD);
    endtask

    task automatic t_fixed();
        send_aw(4'd4, BASE + 32'd16, 8'd2, 3'd2, 2'b00);
        send_w(4'd4, 32'h0101_0101, 4'hF, 1'b0);
        send_w(4'd4, 32'h0202_0202, 4'hF, 1'b0);
        send_w(4'd4, 32'h0303_0303, 4'hF, 1'b1);
        take_b("R6", 4'd4, 2'b00, 0);
        peek("R6", BASE + 32'd16, 32'h0303_0303);
        peek("R6", BASE + 32'd20, 32'h0);
    endtask

    task automatic t_wrap();
        send_aw(4'd6, BASE + 32'h28, 8'd3, 3'd2, 2'b10);
        for (int i = 0; i < 4; i++) send_w(4'd6, 32'hC0DE_0000 + i, 4'hF, i == 3);
        take_b("R7", 4'd6, 2'b00, 0);
        peek("R7", BASE + 32'h28, 32'hC0DE_0000);
        peek("R7", BASE + 32'h2C, 32'hC0DE_0001);
        peek("R7", BASE + 32'h20, 32'hC0DE_0002);
        peek("R7", BASE + 32'h24, 32'hC0DE_0003);
    endtask

    task automatic t_narrow();
        send_aw(4'd7, BASE + 32'h30, 8'd1, 3'd1, 2'b01);
        send_w(4'd7, 32'h0000_BEEF, 4'b0011, 1'b0);
        send_w(4'd7, 32'h0000_CAFE, 4'b0011, 1'b1);
        take_b("R5", 4'd7, 2'b00, 0);
        peek("R5", BASE + 32'h30, 32'hCAFE_BEEF);
    endtask

    task automatic t_decerr();
        send_aw(4'd8, BASE + 32'h3C, 8'd1, 3'd2, 2'b01);
        send_w(4'd8, 32'h5566_7788, 4'hF, 1'b0);
        send_w(4'd8, 32'hDEAD_DEAD, 4'hF, 1'b1);
        take_b("R10", 4'd8, 2'b10, 0);
        peek("R10", BASE + 32'h3C, 32'h5566_7788);
        send_aw(4'd9, 32'h2000_0000, 8'd0, 3'd2, 2'b01);
        send_w(4'd9, 32'hFFFF_FFFF, 4'hF, 1'b1);
        take_b("R10", 4'd9, 2'b10, 0);
    endtask

    task automatic t_slverr();
        send_aw(4'd10, BASE, 8'd3, 3'd2, 2'b01);
        send_w(4'd10, 32'h0, 4'h0, 1'b1);
        chk("R11", {31'd0, b_valid}, 32'd1);
        take_b("R11", 4'd10, 2'b11, 0);
        send_aw(4'd12, BASE, 8'd0, 3'd2, 2'b01);
        send_w(4'd12, 32'h0, 4'h0, 1'b0);
        chk("R11", {31'd0, b_valid}, 32'd1);
        take_b("R11", 4'd12, 2'b11, 0);
        send_aw(4'd13, 32'h2000_0000, 8'd1, 3'd2, 2'b01);
        send_w(4'd13, 32'h0, 4'hF, 1'b1);
        take_b("R11", 4'd13, 2'b11, 0);
        send_aw(4'd5, BASE + 32'd36, 8'd0, 3'd2, 2'b01);
        send_w(4'd6, 32'h0, 4'h0, 1'b1);
        take_b("R11", 4'd5, 2'b11, 0);
    endtask

    task automatic t_hold();
        send_aw(4'd14, BASE + 32'd12, 8'd0, 3'd2, 2'b01);
        send_w(4'd14, 32'h0BAD_F00D, 4'hF, 1'b1);
        aw_valid = 1'b1; aw_id = 4'd1; aw_addr = BASE; aw_len = 8'd0; aw_size = 3'd2; aw_burst = 2'b01;
        take_b("R9", 4'd14, 2'b00, 3);
        aw_valid = 1'b0;
        peek("R1", BASE + 32'd12, 32'h0BAD_F00D);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_incr();
        t_strobe();
        t_fixed();
        t_wrap();
        t_narrow();
        t_decerr();
        t_slverr();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule